// File: doc/BRIEF.md
# Indirect Clock-Synthesizer Register Port

This block holds a small bank of 8-bit clock-synthesizer registers. The host cannot address them directly. It reaches them through one 32-bit control word, with byte-lane access. The low byte of the word picks one of four pixel clocks. The second byte carries a 6-bit bank address and a write-permit flag. The third byte is a data window into the addressed bank register.

Software reaches a bank register in two steps. First it writes the address, and the flag if the access is a store. Then it makes a single-byte access to the window byte. From the stored bank contents the block also derives three values for the selected pixel clock: the feedback-divider byte, a post-divide ratio, and a flag telling whether the video clock is sourced from the synthesizer.

Top module: `pll_window_port`

## Requirements
- R1: After reset the control word reads 0x00000000, every bank register is zero, `fb_div` is 0, `post_ratio` is 1 and `vclk_from_pll` is 0.
- R2: A write updates exactly the control-word bytes whose `bus_be` bit is set (`bus_be[i]` covers bits 8i+7:8i). A read returns the stored word, except for the case in R4.
- R3: Control bits 15:10 hold the bank address and bit 9 holds the write-permit flag. A write with `bus_be` = 4'b0100 while the stored flag is 1 stores `bus_wdata[23:16]` into the addressed bank register.
- R4: A read with `bus_be` = 4'b0100 while the stored flag is 0 returns the addressed bank register on `bus_rdata[23:16]`. The other lanes carry the stored word. Any other read returns the stored window byte.
- R5: These writes never change the bank: a write with any other `bus_be` value that covers byte 2, and a single-byte window write while the flag is 0. Either kind still updates the control-word bytes it enables.
- R6: Control bits 1:0 give the clock select `sel`. `fb_div` equals the bank register at address FB_BASE+`sel` (default FB_BASE = 7).
- R7: The post-divide index is 3 bits. Bits 1:0 are bits 2·sel+1:2·sel of bank register POST_ADDR (default 6). Bit 2 is bit sel+4 of bank register EXT_ADDR (default 11).
- R8: Post-divide indices 0 to 7 give `post_ratio` values 1, 2, 4, 8, 3, 5, 6 and 12.
- R9: `vclk_from_pll` is 1 exactly when bits 1:0 of bank register VCLK_ADDR (default 5) are both 1.
- R10: A bank store or a select change is visible on `fb_div`, `post_ratio` and `vclk_from_pll` in the cycle right after the clock edge that captures the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_rd | input | 1 | Read strobe for the control word |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| fb_div | output | 8 | Feedback-divider byte of the selected clock |
| post_ratio | output | 4 | Decoded post-divide ratio |
| vclk_from_pll | output | 1 | Video clock sourced from the synthesizer |

## Verification
`bus_rdata` is combinational. It is valid in the same cycle as the read strobe, so the bench drives a read after a falling edge and samples it shortly afterwards, before the next rising edge. Every write, whether it lands in the control word or in a bank register, is captured on one rising edge. The derived outputs therefore show the new value from the next falling edge onward, and the bench samples them there. This gives zero cycles of latency for reads and one register stage for writes and derived values. No check depends on the order of processes at a clock edge.

// File: rtl/pll_window_pkg.sv
package pll_window_pkg;

   localparam int BANK_ADDR_W = 6;
   localparam int LANES       = 4;

   // Divide ratio for a 3-bit post-divide index; the upper half holds
   // the non-power-of-two ratios.
   function automatic logic [3:0] ratio_of(input logic [2:0] idx);
      logic [3:0] r;
      case (idx)
         3'd0:    r = 4'd1;
         3'd1:    r = 4'd2;
         3'd2:    r = 4'd4;
         3'd3:    r = 4'd8;
         3'd4:    r = 4'd3;
         3'd5:    r = 4'd5;
         3'd6:    r = 4'd6;
         default: r = 4'd12;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pllw_ctrl_reg.sv
module pllw_ctrl_reg
   import pll_window_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [LANES-1:0]       be,
   input  logic [8*LANES-1:0]     wdata,
   output logic [8*LANES-1:0]     ctrl_q,
   output logic                   pll_we,
   output logic [BANK_ADDR_W-1:0] pll_addr,
   output logic                   wr_flag
);

   localparam logic [LANES-1:0] WINDOW_ONLY = 4'b0100;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            ctrl_q[8*g +: 8] <= 8'h00;
         else if (wr_en && be[g])
            ctrl_q[8*g +: 8] <= wdata[8*g +: 8];
      end
   end

   assign pll_addr = ctrl_q[15:10];
   assign wr_flag  = ctrl_q[9];
   assign pll_we   = wr_en && (be == WINDOW_ONLY) && wr_flag;

   // R2: a disabled lane keeps its byte
   assert_lane_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !be[0]) |=> $stable(ctrl_q[7:0]));

   assert_lane_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be[2]) |=> (ctrl_q[23:16] == $past(wdata[23:16])));

endmodule

// File: rtl/pllw_bank.sv
module pllw_bank
   import pll_window_pkg::*;
#(
   parameter int NUM_REGS = 64
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [BANK_ADDR_W-1:0] waddr,
   input  logic [7:0]             wdata,
   input  logic [BANK_ADDR_W-1:0] raddr,
   output logic [7:0]             rdata,
   output logic [8*NUM_REGS-1:0]  regs_flat
);

   if (NUM_REGS < 1 || NUM_REGS > (1 << BANK_ADDR_W)) begin : g_bad_depth
      $error("pllw_bank: NUM_REGS out of range");
   end

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs_flat[8*k +: 8] <= 8'h00;
         else if (we && (int'(waddr) == k))
            regs_flat[8*k +: 8] <= wdata;
      end
   end

   always_comb begin
      if (int'(raddr) < NUM_REGS)
         rdata = regs_flat[8*int'(raddr) +: 8];
      else
         rdata = 8'h00;
   end

   // R3: a permitted store lands in the addressed register
   assert_bank_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(waddr) < NUM_REGS) |=> (regs_flat[8*int'($past(waddr)) +: 8] == $past(wdata)));

endmodule

// File: rtl/pllw_clk_decode.sv
module pllw_clk_decode
   import pll_window_pkg::*;
#(
   parameter int NUM_REGS   = 64,
   parameter int VCLK_ADDR  = 5,
   parameter int POST_ADDR  = 6,
   parameter int FB_BASE    = 7,
   parameter int EXT_ADDR   = 11,
   parameter bit EXT_IDX_EN = 1'b1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            sel,
   input  logic [8*NUM_REGS-1:0] regs_flat,
   output logic [7:0]            fb_div,
   output logic [3:0]            post_ratio,
   output logic                  vclk_from_pll
);

   localparam int FB_LAST = FB_BASE + 3;

   if (FB_LAST >= NUM_REGS || VCLK_ADDR >= NUM_REGS ||
       POST_ADDR >= NUM_REGS || EXT_ADDR >= NUM_REGS) begin : g_bad_map
      $error("pllw_clk_decode: register map exceeds bank depth");
   end

   logic [2:0] post_idx;
   logic       ext_bit;

   assign fb_div = regs_flat[8*(FB_BASE + int'(sel)) +: 8];

   if (EXT_IDX_EN) begin : g_ext_idx
      assign ext_bit = regs_flat[8*EXT_ADDR + 4 + int'(sel)];
   end else begin : g_no_ext_idx
      assign ext_bit = 1'b0;
   end

   assign post_idx      = {ext_bit, regs_flat[8*POST_ADDR + 2*int'(sel) +: 2]};
   assign post_ratio    = ratio_of(post_idx);
   assign vclk_from_pll = (regs_flat[8*VCLK_ADDR +: 2] == 2'b11);

   // R8: only the eight legal ratios ever appear
   assert_ratio_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      post_ratio inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd12});

endmodule

// File: rtl/pll_window_port.sv
module pll_window_port
   import pll_window_pkg::*;
#(
   parameter int NUM_REGS   = 64,
   parameter int VCLK_ADDR  = 5,
   parameter int POST_ADDR  = 6,
   parameter int FB_BASE    = 7,
   parameter int EXT_ADDR   = 11,
   parameter bit EXT_IDX_EN = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [3:0]  bus_be,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic [7:0]  fb_div,
   output logic [3:0]  post_ratio,
   output logic        vclk_from_pll
);

   localparam logic [3:0] WINDOW_ONLY = 4'b0100;

   logic [31:0]            ctrl_q;
   logic                   pll_we;
   logic [BANK_ADDR_W-1:0] pll_addr;
   logic                   wr_flag;
   logic [7:0]             pll_rd;
   logic [8*NUM_REGS-1:0]  regs_flat;
   logic                   window_read;

   pllw_ctrl_reg u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .be       (bus_be),
      .wdata    (bus_wdata),
      .ctrl_q   (ctrl_q),
      .pll_we   (pll_we),
      .pll_addr (pll_addr),
      .wr_flag  (wr_flag)
   );

   pllw_bank #(.NUM_REGS(NUM_REGS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (pll_we),
      .waddr     (pll_addr),
      .wdata     (bus_wdata[23:16]),
      .raddr     (pll_addr),
      .rdata     (pll_rd),
      .regs_flat (regs_flat)
   );

   pllw_clk_decode #(
      .NUM_REGS   (NUM_REGS),
      .VCLK_ADDR  (VCLK_ADDR),
      .POST_ADDR  (POST_ADDR),
      .FB_BASE    (FB_BASE),
      .EXT_ADDR   (EXT_ADDR),
      .EXT_IDX_EN (EXT_IDX_EN)
   ) u_dec (
      .clk           (clk),
      .rst_n         (rst_n),
      .sel           (ctrl_q[1:0]),
      .regs_flat     (regs_flat),
      .fb_div        (fb_div),
      .post_ratio    (post_ratio),
      .vclk_from_pll (vclk_from_pll)
   );

   assign window_read = bus_rd && (bus_be == WINDOW_ONLY) && !wr_flag;

   always_comb begin
      bus_rdata = ctrl_q;
      if (window_read)
         bus_rdata[23:16] = pll_rd;
   end

   // R5: any access other than a lone window byte leaves the bank alone
   assert_bank_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_be != WINDOW_ONLY) |-> !pll_we);

   // R4: a window read with the flag clear shows the bank byte
   assert_window_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_be == WINDOW_ONLY && !ctrl_q[9]) |-> (bus_rdata[23:16] == pll_rd));

   // R10: a store to the selected divider shows on fb_div one cycle later
   assert_fb_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_we && int'(pll_addr) == FB_BASE + int'(ctrl_q[1:0]))
         |=> (fb_div == $past(bus_wdata[23:16])));

endmodule

// File: tb/pll_window_port_bench.sv
module pll_window_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [3:0]  bus_be = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [7:0]  fb_div;
   logic [3:0]  post_ratio;
   logic        vclk_from_pll;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pll_window_port u_pll_window_port (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_wr        (bus_wr),
      .bus_rd        (bus_rd),
      .bus_be        (bus_be),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .fb_div        (fb_div),
      .post_ratio    (post_ratio),
      .vclk_from_pll (vclk_from_pll)
   );

   // sel, post register, ext register, expected ratio
   localparam int NVEC = 9;
   localparam logic [21:0] VEC [NVEC] = '{
      {2'd0, 8'h00, 8'h00, 4'd1},
      {2'd0, 8'h03, 8'h00, 4'd8},
      {2'd0, 8'h00, 8'hE0, 4'd1},
      {2'd1, 8'h04, 8'h00, 4'd2},
      {2'd1, 8'h08, 8'h20, 4'd6},
      {2'd2, 8'h30, 8'h40, 4'd12},
      {2'd2, 8'h00, 8'h40, 4'd3},
      {2'd3, 8'h40, 8'h80, 4'd5},
      {2'd3, 8'hBF, 8'h7F, 4'd4}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = 4'h0;
   endtask

   task automatic rd(input logic [3:0] be, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_be = be;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_be = 4'h0;
   endtask

   task automatic bank_store(input int addr, input logic [7:0] v);
      wr(4'b0010, {16'h0, 2'b0, addr[5:0], 2'b10, 8'h0});
      wr(4'b0100, {8'h0, v, 16'h0});
   endtask

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(4'b1111, r);
      check("R1 ctrl", r, 32'h0);
      check("R1 fb_div", {24'h0, fb_div}, 32'h0);
      check("R1 ratio", {28'h0, post_ratio}, 32'd1);
      check("R1 vclk", {31'h0, vclk_from_pll}, 32'h0);

      // R2: lane-selective write
      wr(4'b1001, 32'hA5C3_5A96);
      rd(4'b1111, r);
      check("R2 lanes", r, 32'hA500_0096);
      wr(4'b1111, 32'h0);

      // R7/R8 vector table
      for (int i = 0; i < NVEC; i++) begin
         bank_store(6, VEC[i][19:12]);
         bank_store(11, VEC[i][11:4]);
         wr(4'b0001, {30'h0, VEC[i][21:20]});
         @(negedge clk);
         check($sformatf("R7 R8 vec%0d", i), {28'h0, post_ratio}, {28'h0, VEC[i][3:0]});
      end

      // R6: divider per select
      for (int s = 0; s < 4; s++) bank_store(7 + s, 8'h31 + 8'(s * 16));
      for (int s = 0; s < 4; s++) begin
         wr(4'b0001, s);
         @(negedge clk);
         check($sformatf("R6 sel%0d", s), {24'h0, fb_div}, {24'h0, 8'h31 + 8'(s * 16)});
      end

      // R10 and R3: store to selected divider (sel=1), visible next sample
      wr(4'b0001, 32'h1);
      bank_store(8, 8'h55);
      check("R10 R3 fb follow", {24'h0, fb_div}, 32'h55);

      // R5: window write with flag clear changes control only
      wr(4'b0010, {16'h0, 8'h20, 8'h0});
      wr(4'b0100, {8'h0, 8'h99, 16'h0});
      check("R5 flag clear", {24'h0, fb_div}, 32'h55);

      // R4: window read shows bank byte; full read shows stored byte
      rd(4'b0100, r);
      check("R4 window", {24'h0, r[23:16]}, 32'h55);
      rd(4'b1111, r);
      check("R4 full read", r, 32'h0099_2001);

      // R5: wider writes covering byte 2 with the flag set
      wr(4'b0110, {8'h0, 8'h77, 8'h22, 8'h0});
      wr(4'b1100, {8'h11, 8'h66, 16'h0});
      check("R5 wide", {24'h0, fb_div}, 32'h55);
      rd(4'b1111, r);
      check("R5 ctrl updated", r, 32'h1166_2201);

      // R9: video clock source
      bank_store(5, 8'h02);
      check("R9 0x02", {31'h0, vclk_from_pll}, 32'h0);
      bank_store(5, 8'h03);
      check("R9 0x03", {31'h0, vclk_from_pll}, 32'h1);
      bank_store(5, 8'hFD);
      check("R9 0xFD", {31'h0, vclk_from_pll}, 32'h0);
      bank_store(5, 8'hFF);
      check("R9 0xFF", {31'h0, vclk_from_pll}, 32'h1);

      // R1: reset again clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(4'b1111, r);
      check("R1 re-reset ctrl", r, 32'h0);
      check("R1 re-reset fb", {24'h0, fb_div}, 32'h0);
      check("R1 re-reset vclk", {31'h0, vclk_from_pll}, 32'h0);
      rd(4'b0100, r);
      check("R1 re-reset bank", {24'h0, r[23:16]}, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule